// File: doc/BRIEF.md
# Per-Lane Segment Address Translator

This block sits in the issue path of a vector memory unit. For one vector memory instruction it takes a segment code, an operation kind, the access size, an execution mask and one segment-relative offset per lane, and converts each active lane's offset into a flat memory address. The per-wavefront base and size values for the private, spill and read-only regions arrive as inputs. Alongside the addresses it selects the destination pipe (global or local), produces a latency tag, and flags per-lane bound and alignment faults and whole-instruction segment errors.

Each segment has its own lane layout. Private space places lanes side by side at the access size. Global accesses that fall below the per-item private size are redirected into private space through an 8-byte interleave, so that neighbouring lanes occupy neighbouring 8-byte slots. Spill space scales the offset by the spill width. Read-only space adds a base and checks the upper bound. Group space passes the offset through to the local pipe. Results are registered, so they appear one cycle after `valid_i`.

Top module: `seg_xlat`

## Requirements
- R1: `valid_o` is high exactly in the cycle after a cycle with `valid_i` high, and low in the cycle after a cycle with `valid_i` low; it is low after reset.
- R2: Group segment (code 1) with a load (op 0), store (op 1) or atomic (op 2): each active lane's address equals its offset unchanged, `pipe_local_o`=1, `lat_o`=24, and no lane faults.
- R3: Global segment (code 0): an active lane whose offset is at or above `priv_size_i` is passed through unchanged and never faults; `pipe_local_o`=0; `lat_o` is 1 for loads and stores and 64 for atomics.
- R4: Global segment: an active lane with offset below `priv_size_i` becomes (offset>>3)*8*NUM_LANES + lane*8 + (offset mod 8) + `priv_base_i`.
- R5: A redirected global lane whose offset is not a multiple of the access size (`size_i` is log2 of the byte count: 0=1, 1=2, 2=4, 3=8) raises its lane fault.
- R6: Private segment (code 2): the address is offset + lane*bytes + `priv_base_i`, and the lane faults when offset >= `priv_size_i`; `lat_o`=1 on the global pipe.
- R7: Spill segment (code 3): the address is offset*`spill_width_i` + lane*bytes + `spill_base_i` (modulo 2^ADDR_W), and the lane faults when offset >= `spill_size_i`.
- R8: Read-only segment (code 4) with a load: the address is offset + `ro_base_i`, and the lane faults when offset + bytes > `ro_size_i`.
- R9: `seg_err_o` is set, and all addresses, lane faults, `pipe_local_o` and `lat_o` are zero, for: segment codes 5 to 7, op code 3, a store or atomic to read-only, an atomic to private or spill, or a spill access whose `nregs_i` is not 1.
- R10: A lane whose `mask_i` bit is clear outputs address zero and no fault.
- R11: `fault_o` is the OR of all lane fault bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Instruction present this cycle |
| seg_i | input | 3 | Segment code: 0 global, 1 group, 2 private, 3 spill, 4 read-only |
| op_i | input | 2 | Operation: 0 load, 1 store, 2 atomic |
| size_i | input | 2 | log2 of access size in bytes |
| nregs_i | input | 3 | Number of data registers of the access |
| mask_i | input | NUM_LANES | Execution mask, bit n for lane n |
| offset_i | input | NUM_LANES*ADDR_W | Per-lane offsets, lane n at bits n*ADDR_W upward |
| priv_base_i | input | ADDR_W | Private region base |
| priv_size_i | input | ADDR_W | Per-item private size |
| spill_base_i | input | ADDR_W | Spill region base |
| spill_width_i | input | ADDR_W | Spill offset scale |
| spill_size_i | input | ADDR_W | Per-item spill size |
| ro_base_i | input | ADDR_W | Read-only region base |
| ro_size_i | input | ADDR_W | Read-only region size |
| valid_o | output | 1 | Results valid |
| addr_o | output | NUM_LANES*ADDR_W | Translated addresses, same lane layout as offset_i |
| lane_fault_o | output | NUM_LANES | Per-lane bound or alignment fault |
| fault_o | output | 1 | Any lane fault |
| seg_err_o | output | 1 | Unsupported segment/operation combination |
| pipe_local_o | output | 1 | 1 selects the local pipe, 0 the global pipe |
| lat_o | output | 7 | Latency tag |

## Verification
The assertions assume the inputs are steady around the rising clock edge and that `valid_i` is a known value once reset is released; the offsets and region values may be anything. The stimulus drives every input on the falling edge, so each sampled value is settled. Random offsets are drawn from windows around each region size so that in-range, boundary and out-of-range lanes occur for every segment, and the region sizes are kept small relative to the offset width so that redirection and faults both occur often.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;
  localparam logic [2:0] SEG_GLOBAL  = 3'd0;
  localparam logic [2:0] SEG_GROUP   = 3'd1;
  localparam logic [2:0] SEG_PRIVATE = 3'd2;
  localparam logic [2:0] SEG_SPILL   = 3'd3;
  localparam logic [2:0] SEG_RDONLY  = 3'd4;

  localparam logic [1:0] OP_LOAD   = 2'd0;
  localparam logic [1:0] OP_STORE  = 2'd1;
  localparam logic [1:0] OP_ATOMIC = 2'd2;

  localparam int unsigned LAT_W = 7;
  localparam logic [LAT_W-1:0] LAT_LOCAL  = 7'd24;
  localparam logic [LAT_W-1:0] LAT_GLOBAL = 7'd1;
  localparam logic [LAT_W-1:0] LAT_ATOMIC = 7'd64;

  typedef struct packed {
    logic             ok;
    logic             local_pipe;
    logic [LAT_W-1:0] lat;
  } route_t;
endpackage

// File: rtl/seg_xlat_route.sv
module seg_xlat_route
  import seg_xlat_pkg::*;
(
  input  logic [2:0] seg_i,
  input  logic [1:0] op_i,
  input  logic [2:0] nregs_i,
  output route_t     route_o
);
  logic op_bad, seg_bad, ro_bad, atom_bad, spill_bad;

  always_comb begin
    op_bad    = (op_i == 2'd3);
    seg_bad   = (seg_i > SEG_RDONLY);
    ro_bad    = (seg_i == SEG_RDONLY) && (op_i != OP_LOAD);
    atom_bad  = (op_i == OP_ATOMIC) && (seg_i != SEG_GLOBAL) && (seg_i != SEG_GROUP);
    spill_bad = (seg_i == SEG_SPILL) && (nregs_i != 3'd1);

    route_o.ok         = !(op_bad || seg_bad || ro_bad || atom_bad || spill_bad);
    route_o.local_pipe = 1'b0;
    route_o.lat        = '0;
    if (route_o.ok) begin
      if (seg_i == SEG_GROUP) begin
        route_o.local_pipe = 1'b1;
        route_o.lat        = LAT_LOCAL;
      end else if (op_i == OP_ATOMIC) begin
        route_o.lat = LAT_ATOMIC;
      end else begin
        route_o.lat = LAT_GLOBAL;
      end
    end
  end
endmodule

// File: rtl/seg_xlat_lane.sv
module seg_xlat_lane
  import seg_xlat_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LANE_LG = 2,
  parameter int unsigned LANE = 0
) (
  input  logic              active_i,
  input  logic              ok_i,
  input  logic [2:0]        seg_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] off_i,
  input  logic [ADDR_W-1:0] priv_base_i,
  input  logic [ADDR_W-1:0] priv_size_i,
  input  logic [ADDR_W-1:0] spill_base_i,
  input  logic [ADDR_W-1:0] spill_width_i,
  input  logic [ADDR_W-1:0] spill_size_i,
  input  logic [ADDR_W-1:0] ro_base_i,
  input  logic [ADDR_W-1:0] ro_size_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              fault_o
);
  localparam logic [ADDR_W-1:0] LANE_V = ADDR_W'(LANE);

  logic [ADDR_W-1:0] bytes, lane_span, ilv_addr, spill_scaled;
  logic [ADDR_W:0]   ro_end;
  logic              in_priv, misaligned;

  always_comb begin
    bytes        = ADDR_W'(1) << size_i;
    lane_span    = LANE_V << size_i;
    // 8-byte interleave: lanes share each 8-byte column, columns stacked by lane count
    ilv_addr     = ((off_i >> 3) << (3 + LANE_LG)) + (LANE_V << 3)
                   + {{(ADDR_W-3){1'b0}}, off_i[2:0]} + priv_base_i;
    spill_scaled = off_i * spill_width_i;
    ro_end       = {1'b0, off_i} + {1'b0, bytes};
    in_priv      = off_i < priv_size_i;
    misaligned   = (off_i & (bytes - ADDR_W'(1))) != '0;
  end

  always_comb begin
    addr_o  = '0;
    fault_o = 1'b0;
    if (active_i && ok_i) begin
      unique case (seg_i)
        SEG_GLOBAL: begin
          if (in_priv) begin
            addr_o  = ilv_addr;
            fault_o = misaligned;
          end else begin
            addr_o = off_i;
          end
        end
        SEG_GROUP: addr_o = off_i;
        SEG_PRIVATE: begin
          addr_o  = off_i + lane_span + priv_base_i;
          fault_o = !in_priv;
        end
        SEG_SPILL: begin
          addr_o  = spill_scaled + lane_span + spill_base_i;
          fault_o = off_i >= spill_size_i;
        end
        SEG_RDONLY: begin
          addr_o  = off_i + ro_base_i;
          fault_o = ro_end > {1'b0, ro_size_i};
        end
        default: begin
          addr_o  = '0;
          fault_o = 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/seg_xlat.sv
module seg_xlat
  import seg_xlat_pkg::*;
#(
  parameter int unsigned NUM_LANES = 4,
  parameter int unsigned ADDR_W = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          valid_i,
  input  logic [2:0]                    seg_i,
  input  logic [1:0]                    op_i,
  input  logic [1:0]                    size_i,
  input  logic [2:0]                    nregs_i,
  input  logic [NUM_LANES-1:0]          mask_i,
  input  logic [NUM_LANES*ADDR_W-1:0]   offset_i,
  input  logic [ADDR_W-1:0]             priv_base_i,
  input  logic [ADDR_W-1:0]             priv_size_i,
  input  logic [ADDR_W-1:0]             spill_base_i,
  input  logic [ADDR_W-1:0]             spill_width_i,
  input  logic [ADDR_W-1:0]             spill_size_i,
  input  logic [ADDR_W-1:0]             ro_base_i,
  input  logic [ADDR_W-1:0]             ro_size_i,
  output logic                          valid_o,
  output logic [NUM_LANES*ADDR_W-1:0]   addr_o,
  output logic [NUM_LANES-1:0]          lane_fault_o,
  output logic                          fault_o,
  output logic                          seg_err_o,
  output logic                          pipe_local_o,
  output logic [LAT_W-1:0]              lat_o
);
  localparam int unsigned LANE_LG = $clog2(NUM_LANES);

  initial begin
    if ((1 << LANE_LG) != NUM_LANES) $error("NUM_LANES must be a power of two");
  end

  route_t                        route;
  logic [NUM_LANES*ADDR_W-1:0]   addr_d;
  logic [NUM_LANES-1:0]          fault_d;

  seg_xlat_route i_route (
    .seg_i   (seg_i),
    .op_i    (op_i),
    .nregs_i (nregs_i),
    .route_o (route)
  );

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    seg_xlat_lane #(
      .ADDR_W  (ADDR_W),
      .LANE_LG (LANE_LG),
      .LANE    (l)
    ) i_lane (
      .active_i      (mask_i[l]),
      .ok_i          (route.ok),
      .seg_i         (seg_i),
      .size_i        (size_i),
      .off_i         (offset_i[l*ADDR_W +: ADDR_W]),
      .priv_base_i   (priv_base_i),
      .priv_size_i   (priv_size_i),
      .spill_base_i  (spill_base_i),
      .spill_width_i (spill_width_i),
      .spill_size_i  (spill_size_i),
      .ro_base_i     (ro_base_i),
      .ro_size_i     (ro_size_i),
      .addr_o        (addr_d[l*ADDR_W +: ADDR_W]),
      .fault_o       (fault_d[l])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o      <= 1'b0;
      addr_o       <= '0;
      lane_fault_o <= '0;
      fault_o      <= 1'b0;
      seg_err_o    <= 1'b0;
      pipe_local_o <= 1'b0;
      lat_o        <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        addr_o       <= addr_d;
        lane_fault_o <= fault_d;
        fault_o      <= |fault_d;
        seg_err_o    <= !route.ok;
        pipe_local_o <= route.local_pipe;
        lat_o        <= route.lat;
      end
    end
  end
endmodule

// File: rtl/seg_xlat_chk.sv
module seg_xlat_chk
  import seg_xlat_pkg::*;
#(
  parameter int unsigned NUM_LANES = 4,
  parameter int unsigned ADDR_W = 32
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        valid_i,
  input logic [2:0]                  seg_i,
  input logic [1:0]                  op_i,
  input logic [NUM_LANES-1:0]        mask_i,
  input logic                        valid_o,
  input logic [NUM_LANES*ADDR_W-1:0] addr_o,
  input logic [NUM_LANES-1:0]        lane_fault_o,
  input logic                        fault_o,
  input logic                        seg_err_o,
  input logic                        pipe_local_o,
  input logic [LAT_W-1:0]            lat_o
);
  assert_valid_follow_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_valid_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  assert_group_route_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && seg_i == SEG_GROUP && op_i != 2'd3) |=>
      (pipe_local_o && lat_o == LAT_LOCAL && !fault_o && !seg_err_o));

  assert_global_atomic_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && seg_i == SEG_GLOBAL && op_i == OP_ATOMIC) |=>
      (!pipe_local_o && lat_o == LAT_ATOMIC));

  assert_ro_store_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && seg_i == SEG_RDONLY && op_i == OP_STORE) |=> seg_err_o);

  assert_bad_seg_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && seg_i > SEG_RDONLY) |=>
      (seg_err_o && addr_o == '0 && lane_fault_o == '0 && lat_o == '0));

  assert_err_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && seg_err_o) |-> (!fault_o && !pipe_local_o));

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane_chk
    assert_inactive_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && !mask_i[l]) |=>
        (addr_o[l*ADDR_W +: ADDR_W] == '0 && !lane_fault_o[l]));
  end

  assert_fault_or_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (fault_o == (|lane_fault_o)));
endmodule

bind seg_xlat seg_xlat_chk #(
  .NUM_LANES (NUM_LANES),
  .ADDR_W    (ADDR_W)
) i_seg_xlat_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_i      (valid_i),
  .seg_i        (seg_i),
  .op_i         (op_i),
  .mask_i       (mask_i),
  .valid_o      (valid_o),
  .addr_o       (addr_o),
  .lane_fault_o (lane_fault_o),
  .fault_o      (fault_o),
  .seg_err_o    (seg_err_o),
  .pipe_local_o (pipe_local_o),
  .lat_o        (lat_o)
);

// File: tb/test_seg_xlat.sv
module test_seg_xlat;
  localparam int unsigned NL = 4;
  localparam int unsigned AW = 32;
  localparam int unsigned LG = $clog2(NL);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          valid;
  logic [2:0]    seg;
  logic [1:0]    op;
  logic [1:0]    size;
  logic [2:0]    nregs;
  logic [NL-1:0] mask;
  logic [AW-1:0] off [NL];
  logic [NL*AW-1:0] off_flat;
  logic [AW-1:0] pbase, psz, sbase, swid, ssz, rbase, rsz;

  logic              valid_o, fault_o, seg_err_o, pipe_local_o;
  logic [NL*AW-1:0]  addr_o;
  logic [NL-1:0]     lane_fault_o;
  logic [6:0]        lat_o;

  always_comb
    for (int i = 0; i < NL; i++) off_flat[i*AW +: AW] = off[i];

  seg_xlat #(.NUM_LANES(NL), .ADDR_W(AW)) i_seg_xlat (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .seg_i(seg), .op_i(op),
    .size_i(size), .nregs_i(nregs), .mask_i(mask), .offset_i(off_flat),
    .priv_base_i(pbase), .priv_size_i(psz), .spill_base_i(sbase),
    .spill_width_i(swid), .spill_size_i(ssz), .ro_base_i(rbase), .ro_size_i(rsz),
    .valid_o(valid_o), .addr_o(addr_o), .lane_fault_o(lane_fault_o),
    .fault_o(fault_o), .seg_err_o(seg_err_o), .pipe_local_o(pipe_local_o),
    .lat_o(lat_o)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_ok();
    return !(op == 2'd3 || seg > 3'd4 || (seg == 3'd4 && op != 2'd0) ||
             (op == 2'd2 && seg > 3'd1) || (seg == 3'd3 && nregs != 3'd1));
  endfunction

  function automatic string seg_tag();
    case (seg)
      3'd0: return "R3/R4/R5";
      3'd1: return "R2";
      3'd2: return "R6";
      3'd3: return "R7";
      3'd4: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic exp_lane(int ln, output logic [AW-1:0] a, output logic f);
    logic [AW-1:0] o, b;
    o = off[ln];
    b = AW'(1) << size;
    a = '0;
    f = 1'b0;
    if (exp_ok() && mask[ln]) begin
      case (seg)
        3'd0: if (o < psz) begin
                a = (o / 8) * 8 * NL + AW'(ln) * 8 + (o % 8) + pbase;
                f = (o % b) != 0;
              end else a = o;
        3'd1: a = o;
        3'd2: begin a = o + AW'(ln) * b + pbase; f = o >= psz; end
        3'd3: begin a = o * swid + AW'(ln) * b + sbase; f = o >= ssz; end
        default: begin a = o + rbase; f = (33'(o) + 33'(b)) > 33'(rsz); end
      endcase
    end
  endtask

  task automatic send_check();
    logic [AW-1:0] ea;
    logic ef, anyf;
    logic [6:0] elat;
    @(negedge clk);
    valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    chk("R1 valid_o", 64'(valid_o), 64'd1);
    anyf = 1'b0;
    for (int l = 0; l < NL; l++) begin
      exp_lane(l, ea, ef);
      anyf |= ef;
      if (!mask[l])
        chk("R10 inactive lane addr", 64'(addr_o[l*AW +: AW]), 64'(ea));
      else
        chk(seg_tag(), 64'(addr_o[l*AW +: AW]), 64'(ea));
      chk(mask[l] ? "lane fault R5/R6/R7/R8" : "R10 inactive fault",
          64'(lane_fault_o[l]), 64'(ef));
    end
    chk("R11 fault_o", 64'(fault_o), 64'(anyf));
    chk("R9 seg_err_o", 64'(seg_err_o), 64'(!exp_ok()));
    elat = !exp_ok() ? 7'd0 : (seg == 3'd1) ? 7'd24 : (op == 2'd2) ? 7'd64 : 7'd1;
    chk("R2/R3 lat_o", 64'(lat_o), 64'(elat));
    chk("R2/R3 pipe_local_o", 64'(pipe_local_o), 64'(exp_ok() && seg == 3'd1));
  endtask

  task automatic set_regions();
    pbase = $urandom; psz = 32'd64 + ($urandom % 192);
    sbase = $urandom; swid = 32'd4 + ($urandom % 61); ssz = 32'd32 + ($urandom % 96);
    rbase = $urandom; rsz = 32'd64 + ($urandom % 192);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EC0_1234));
    valid = 0; seg = 0; op = 0; size = 0; nregs = 1; mask = '0;
    for (int i = 0; i < NL; i++) off[i] = '0;
    pbase = 32'h1000; psz = 32'd64; sbase = 32'h8000; swid = 32'd16; ssz = 32'd32;
    rbase = 32'h4000; rsz = 32'd100;
    repeat (3) @(negedge clk);
    chk("R1 reset valid_o", 64'(valid_o), 64'd0);
    chk("R11 reset fault_o", 64'(fault_o), 64'd0);
    chk("R9 reset addr_o", 64'(addr_o), 64'd0);
    rst_n = 1'b1;

    // R4: interleave with lane 2, offset 13 -> 8*4 + 16 + 5 + base
    seg = 0; op = 0; size = 0; mask = '1;
    off[0] = 32'd0; off[1] = 32'd13; off[2] = 32'd13; off[3] = 32'd200;
    send_check();
    chk("R4 lane2 interleave", 64'(addr_o[2*AW +: AW]), 64'(32'h1000 + 32 + 16 + 5));
    chk("R3 lane3 passthrough", 64'(addr_o[3*AW +: AW]), 64'd200);
    @(negedge clk);
    chk("R1 idle valid_o", 64'(valid_o), 64'd0);

    // R5: misaligned 4-byte redirect on lane 1
    size = 2; off[1] = 32'd6; off[2] = 32'd8;
    send_check();
    chk("R5 misaligned fault", 64'(lane_fault_o), 64'b0010);

    // R8: read-only boundary, off+4 == size ok, off+4 > size faults
    seg = 4; off[0] = 32'd96; off[1] = 32'd97; off[2] = 32'd0; off[3] = 32'd99;
    send_check();
    chk("R8 boundary faults", 64'(lane_fault_o), 64'b1010);
    op = 1;
    send_check();
    chk("R9 ro store seg_err", 64'(seg_err_o), 64'd1);

    // R7: spill vector access is a segment error; scalar bound at limit
    seg = 3; op = 0; nregs = 2;
    send_check();
    nregs = 1; off[0] = 32'd31; off[1] = 32'd32;
    send_check();
    chk("R7 spill bound", 64'(lane_fault_o[1:0]), 64'b10);

    // R6 bound and R10 masked lanes
    seg = 2; mask = 4'b0101; off[0] = 32'd63; off[2] = 32'd64;
    send_check();
    chk("R10 masked lane zero", 64'(addr_o[AW +: AW]), 64'd0);

    // R9: atomic to private, bad op, bad seg; R3 global atomic lat 64
    mask = '1; op = 2; send_check();
    seg = 0; op = 3; send_check();
    seg = 6; op = 0; send_check();
    seg = 0; op = 2; send_check();
    chk("R3 atomic latency", 64'(lat_o), 64'd64);
    seg = 1; send_check();
    chk("R2 group atomic latency", 64'(lat_o), 64'd24);

    for (int n = 0; n < 400; n++) begin
      if (n % 16 == 0) set_regions();
      seg = ($urandom % 8 < 6) ? 3'($urandom % 5) : 3'($urandom);
      op = ($urandom % 10 == 0) ? 2'd3 : 2'($urandom % 3);
      size = 2'($urandom);
      nregs = ($urandom % 4 == 0) ? 3'($urandom % 5) : 3'd1;
      mask = NL'($urandom);
      for (int i = 0; i < NL; i++)
        case ($urandom % 4)
          0: off[i] = $urandom % (psz + 16);
          1: off[i] = ($urandom % (psz / 8)) * (AW'(1) << size);
          2: off[i] = $urandom % (ssz + 8);
          default: off[i] = ($urandom % 4 == 0) ? $urandom : rsz - ($urandom % 12);
        endcase
      send_check();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule